// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control of a successive-approximation converter that sits on a processor bus. Three control levels gate it: an active-high enable, an active-low select and a read/convert level (high means read, low means convert). A conversion is armed by whichever of the three arrives at its active level last, so any of them may be used as the trigger. When all three are active, the block starts once that condition has held for a programmable number of clocks. It then walks a binary search one bit per clock against an external comparator bit. It raises a busy flag for the duration and loads a 12-bit result when the search ends.

A length-select input picks a short 8-bit search or the full 12-bit search and is captured on every start transition. When the search is short, the bits below the top eight are forced to zero. The result is presented on a data port only while the bus is in the read state and the converter is idle. With enable tied high and select tied low, the block runs stand-alone: a falling read/convert level starts a conversion and a high level reads the previous result.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After reset, `busyFlag` is 0 and the stored result is zero, so `dataOut` reads 0.
- R2: The start condition is `chipEn`=1, `chipSelN`=0 and `readMode`=0 together. It may be completed by any one of the three or by all three at once. `busyFlag` rises on the MIN_LOW_CYC-th rising edge at which the condition is seen.
- R3: If the start condition is held for fewer than MIN_LOW_CYC clock edges, no conversion begins.
- R4: `lenShort` is captured on every rising clock edge where the start condition becomes true. 1 selects 8 search steps and 0 selects 12.
- R5: The search runs from bit 11 down. One comparator sample is taken per clock, and each result bit equals the `cmpIn` value sampled at its step (1 keeps the bit, 0 clears it).
- R6: After an 8-step conversion, result bits 3..0 are 0.
- R7: `busyFlag` stays high for exactly as many clocks as there are search steps. It falls on the same edge that loads the result.
- R8: While `busyFlag` is high, new start transitions neither restart nor end the running conversion.
- R9: A start transition during a conversion recaptures `lenShort`. The running conversion then ends according to the new length.
- R10: `dataOe` = `chipEn` AND NOT `chipSelN` AND `readMode` AND NOT `busyFlag`. `dataOut` shows the result when `dataOe` is 1 and is 0 otherwise.
- R11: A start condition that stays held after a conversion ends does not start another; a fresh transition is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chipEn | input | 1 | Enable, active high |
| chipSelN | input | 1 | Select, active low |
| readMode | input | 1 | 1 = read, 0 = convert |
| lenShort | input | 1 | 1 = 8-step conversion, 0 = 12-step |
| cmpIn | input | 1 | Comparator decision for the current trial bit |
| busyFlag | output | 1 | High while a conversion runs |
| dataOe | output | 1 | Result output enable |
| dataOut | output | 12 | Result, zero when not enabled |

## Verification
The embedded properties watch, on every cycle, that a conversion only begins after the start condition has been held long enough, and that a mid-run start transition recaptures the length without stopping the search. They also check that busy never outlasts twelve clocks and that the result register changes only on the final step. Only the bench scenarios can show that the result actually matches the comparator pattern for every 12-bit code and every 8-bit prefix. The same holds for each of the three inputs acting as the trigger, for a relatched length taking effect on the running conversion, and for a held start level being refused after completion.

// File: rtl/conv_pkg.sv
`timescale 1ns/1ps
package conv_pkg;
  localparam int IDX_W = 5;

  typedef struct packed {
    logic             start;
    logic             step;
    logic             finish;
    logic             shortLen;
    logic [IDX_W-1:0] idx;
  } convStb_t;
endpackage

// File: rtl/conv_ctrl.sv
`timescale 1ns/1ps
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SHORT_BITS  = 8,
  parameter int MIN_LOW_CYC = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     chipEn,
  input  logic     chipSelN,
  input  logic     readMode,
  input  logic     lenShort,
  output convStb_t stb,
  output logic     busy
);
  localparam int CNT_W     = $clog2(MIN_LOW_CYC + 1);
  localparam int SHORT_LSB = RES_BITS - SHORT_BITS;

  logic             actPrev;
  logic             armedQ;
  logic [CNT_W-1:0] holdCnt;
  logic [IDX_W-1:0] idx;
  logic             lenQ;

  logic startAct, startEdge, runOk, startGo, finish;
  logic [IDX_W-1:0] lastIdx;

  assign startAct  = chipEn & ~chipSelN & ~readMode;
  assign startEdge = startAct & ~actPrev;
  assign runOk     = startEdge ? ~busy : armedQ;
  assign startGo   = startAct && runOk && !busy &&
                     (holdCnt == CNT_W'(MIN_LOW_CYC - 1));
  assign lastIdx   = lenQ ? IDX_W'(SHORT_LSB) : '0;
  assign finish    = busy && (idx <= lastIdx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      actPrev <= 1'b0;
      armedQ  <= 1'b0;
      holdCnt <= '0;
    end else begin
      actPrev <= startAct;
      armedQ  <= startAct & runOk;
      if (!startAct)
        holdCnt <= '0;
      else if (holdCnt != CNT_W'(MIN_LOW_CYC))
        holdCnt <= holdCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lenQ <= 1'b0;
    else if (startEdge)
      lenQ <= lenShort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (startGo) begin
      busy <= 1'b1;
      idx  <= IDX_W'(RES_BITS - 1);
    end else if (busy) begin
      if (finish)
        busy <= 1'b0;
      else
        idx <= idx - 1'b1;
    end
  end

  always_comb begin
    stb.start    = startGo;
    stb.step     = busy;
    stb.finish   = finish;
    stb.shortLen = lenQ;
    stb.idx      = idx;
  end

  // assertion-only run length counter
  logic [IDX_W:0] busyRun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busyRun <= '0;
    else if (!busy)   busyRun <= '0;
    else              busyRun <= busyRun + 1'b1;
  end

  p_start_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(startAct) && $past(holdCnt) == CNT_W'(MIN_LOW_CYC - 1)));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && startEdge && !finish) |=> (busy && idx == $past(idx) - 1'b1));

  p_len_relatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    startEdge |=> (lenQ == $past(lenShort)));

  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busyRun < (IDX_W+1)'(RES_BITS)));
endmodule

// File: rtl/conv_datapath.sv
`timescale 1ns/1ps
module conv_datapath
  import conv_pkg::*;
#(
  parameter int RES_BITS   = 12,
  parameter int SHORT_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  convStb_t            stb,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] result
);
  localparam int DROP_BITS = RES_BITS - SHORT_BITS;
  localparam logic [RES_BITS-1:0] SHORT_MASK = {{SHORT_BITS{1'b1}}, {DROP_BITS{1'b0}}};

  logic [RES_BITS-1:0] sar, sarNext, keepMask;

  always_comb begin
    sarNext = sar;
    for (int b = 0; b < RES_BITS; b++) begin
      if (stb.idx == IDX_W'(b))
        sarNext[b] = cmpIn;
      else if (!stb.finish && stb.idx == IDX_W'(b + 1))
        sarNext[b] = 1'b1;
    end
    keepMask = stb.shortLen ? SHORT_MASK : '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar    <= '0;
      result <= '0;
    end else begin
      if (stb.start)
        sar <= {1'b1, {(RES_BITS-1){1'b0}}};
      else if (stb.step)
        sar <= sarNext;
      if (stb.step && stb.finish)
        result <= sarNext & keepMask;
    end
  end

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.step && stb.finish) |=> $stable(result));

  p_short_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.step && stb.finish && stb.shortLen) |=> ((result & ~SHORT_MASK) == '0));
endmodule

// File: rtl/conv_seq_ctrl.sv
`timescale 1ns/1ps
module conv_seq_ctrl
  import conv_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int SHORT_BITS  = 8,
  parameter int MIN_LOW_CYC = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chipEn,
  input  logic                chipSelN,
  input  logic                readMode,
  input  logic                lenShort,
  input  logic                cmpIn,
  output logic                busyFlag,
  output logic                dataOe,
  output logic [RES_BITS-1:0] dataOut
);
  convStb_t            stb;
  logic [RES_BITS-1:0] result;

  conv_ctrl #(
    .RES_BITS(RES_BITS), .SHORT_BITS(SHORT_BITS), .MIN_LOW_CYC(MIN_LOW_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chipEn(chipEn), .chipSelN(chipSelN),
    .readMode(readMode), .lenShort(lenShort), .stb(stb), .busy(busyFlag)
  );

  conv_datapath #(
    .RES_BITS(RES_BITS), .SHORT_BITS(SHORT_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cmpIn(cmpIn), .result(result)
  );

  assign dataOe  = chipEn & ~chipSelN & readMode & ~busyFlag;
  assign dataOut = dataOe ? result : '0;

  p_quiet_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busyFlag |-> (dataOut == '0));

  p_fall_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busyFlag) |-> $past(stb.finish));
endmodule

// File: tb/conv_seq_ctrl_test.sv
`timescale 1ns/1ps
module conv_seq_ctrl_test;
  localparam int MINL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chipEn = 1'b1, chipSelN = 1'b0, readMode = 1'b1, lenShort = 1'b0, cmpIn = 1'b0;
  logic busyFlag, dataOe;
  logic [11:0] dataOut;

  int nTests = 0;
  int nFail  = 0;

  always #2.5 clk = ~clk;

  conv_seq_ctrl #(.RES_BITS(12), .SHORT_BITS(8), .MIN_LOW_CYC(MINL)) uut (
    .clk(clk), .rst_n(rst_n), .chipEn(chipEn), .chipSelN(chipSelN),
    .readMode(readMode), .lenShort(lenShort), .cmpIn(cmpIn),
    .busyFlag(busyFlag), .dataOe(dataOe), .dataOut(dataOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // lastSig: 0 read/convert last, 1 select last, 2 enable last, 3 all at once
  task automatic convert(input int lastSig, input bit shortL, input logic [11:0] pat,
                         input int midAt, input bit midLen, input bit holdAfter);
    bit effShort;
    int steps;
    logic [11:0] expv;
    @(negedge clk);
    case (lastSig)
      1: begin chipSelN = 1'b1; readMode = 1'b0; end
      2: begin chipEn = 1'b0; readMode = 1'b0; end
      3: begin chipEn = 1'b0; chipSelN = 1'b1; readMode = 1'b1; end
      default: readMode = 1'b1;
    endcase
    @(negedge clk);
    @(negedge clk);
    lenShort = shortL; chipEn = 1'b1; chipSelN = 1'b0; readMode = 1'b0;
    repeat (MINL - 1) @(negedge clk);
    chk(busyFlag == 1'b0, "R3 early start", int'(busyFlag), 0);
    @(negedge clk);
    chk(busyFlag == 1'b1, "R2 start trigger", int'(busyFlag), 1);
    effShort = (midAt >= 0) ? midLen : shortL;
    steps = effShort ? 8 : 12;
    expv = effShort ? (pat & 12'hFF0) : pat;
    for (int j = 0; j < steps; j++) begin
      if (j > 0) @(negedge clk);
      cmpIn = pat[11-j];
      if (midAt >= 0 && j == midAt) begin
        readMode = 1'b1;
        #1 chk(dataOe == 1'b0 && dataOut == 12'h0, "R10 busy read", int'(dataOut), 0);
      end
      if (midAt >= 0 && j == midAt + 1) begin
        readMode = 1'b0;
        lenShort = midLen;
      end
    end
    chk(busyFlag == 1'b1, "R7 busy through last step", int'(busyFlag), 1);
    @(negedge clk);
    chk(busyFlag == 1'b0, effShort ? "R4 R7 short length" : "R4 R7 full length", int'(busyFlag), 0);
    if (holdAfter) begin
      repeat (2 * MINL) @(negedge clk);
      chk(busyFlag == 1'b0, "R11 held level no restart", int'(busyFlag), 0);
    end
    readMode = 1'b1;
    #1;
    if (midAt >= 0)
      chk(dataOe && dataOut == expv, "R9 R8 result", int'(dataOut), int'(expv));
    else
      chk(dataOe && dataOut == expv, effShort ? "R6 short result" : "R5 full result",
          int'(dataOut), int'(expv));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R2 actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busyFlag == 1'b0 && dataOut == 12'h0, "R1 in reset", int'(dataOut), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busyFlag == 1'b0 && dataOut == 12'h0, "R1 after reset", int'(dataOut), 0);

    // R5 R2: every 12-bit code, rotating the trigger input
    for (int p = 0; p < 4096; p++)
      convert(p % 4, 1'b0, 12'(p), -1, 1'b0, 1'b0);

    // R4 R6: every 8-bit prefix with low bits driven high
    for (int p = 0; p < 256; p++)
      convert((p + 1) % 4, 1'b1, {8'(p), 4'hF}, -1, 1'b0, 1'b0);

    // R9: relatch to short during a full run, and to full during a short run
    convert(0, 1'b0, 12'hB7D, 2, 1'b1, 1'b0);
    convert(0, 1'b0, 12'h5AF, 3, 1'b1, 1'b0);
    convert(1, 1'b1, 12'hC3E, 2, 1'b0, 1'b0);

    // R8: mid-run start transitions with unchanged length
    convert(0, 1'b0, 12'h9E1, 4, 1'b0, 1'b0);
    convert(2, 1'b1, 12'h6D7, 1, 1'b1, 1'b0);

    // R11: level kept active after completion
    convert(0, 1'b0, 12'h3C9, -1, 1'b0, 1'b1);
    convert(3, 1'b1, 12'hE4B, -1, 1'b0, 1'b1);

    // R3: pulses shorter than the minimum width
    for (int w = 1; w < MINL; w++) begin
      @(negedge clk);
      readMode = 1'b0;
      repeat (w) @(negedge clk);
      readMode = 1'b1;
      for (int k = 0; k < MINL + 2; k++) begin
        @(negedge clk);
        chk(busyFlag == 1'b0, "R3 short pulse", int'(busyFlag), 0);
      end
    end

    // R10: enable gating over all input levels, last result 12'hE40
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chipEn = c[2]; chipSelN = c[1]; readMode = c[0];
      #1;
      begin
        bit expOe;
        expOe = c[2] & ~c[1] & c[0];
        chk(dataOe == expOe && dataOut == (expOe ? 12'hE40 : 12'h0), "R10 gating",
            int'(dataOut), expOe ? 32'hE40 : 0);
      end
    end
    @(negedge clk);
    chipEn = 1'b1; chipSelN = 1'b0; readMode = 1'b1;
    repeat (MINL + 2) @(negedge clk);
    chk(busyFlag == 1'b0, "R3 R10 sweep started nothing", int'(busyFlag), 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule